// File: doc/BRIEF.md
# Write-Permit and Status Controller for a Serial Memory

This block sits behind the command decoder of a serial memory's front end and owns the status register. That register has four kinds of field: a protect-pin enable, a two-bit protected-range selector, the write-enable latch and the write-in-progress flag. The front end sends single-cycle strobes:

- set latch
- clear latch
- status write, with its data byte
- array write, with its byte address
- end of frame, sent when chip select rises

For every write request the block answers in the same cycle with a permit signal. The front end may only schedule the byte when permit is high.

An accepted request is held as pending until the frame ends. At that point an internal write cycle starts and runs for a parameterised number of clock cycles. During that cycle the status byte reads all ones, and every request is turned down. When the cycle ends, the write-enable latch drops. If the cycle was a status write, the new pin-enable and range bits take effect at that moment. The status byte is always presented, so the read-status command can return it whenever it is asked for.

Top module: `wbp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00: pin enable 0, range 00, latch 0, busy 0.
- R2: The set strobe makes the latch 1 and the clear strobe makes it 0. Both strobes are ignored while a write cycle runs.
- R3: When idle, the status byte has the pin enable in bit 7, zeros in bits 6:4, the range selector in bits 3:2, the latch in bit 1 and the busy flag in bit 0.
- R4: Permit is high only when all three hold: the latch is 1, no write cycle runs, and end of frame is low in that cycle. An end of frame with nothing accepted starts no cycle.
- R5: An array write is refused for protected addresses. Range 00 protects nothing. Range 01 protects the top quarter (0x600 to 0x7FF with 11 address bits). Range 10 protects the top half (0x400 and up). Range 11 protects everything.
- R6: When the pin enable is 1 and the protect pin is low, a status write is refused. When the pin enable is 0, the pin has no effect. Array writes never depend on the pin.
- R7: An accepted status write loads the pin enable from data bit 7 and the range from data bits 3:2. The other data bits have no effect. The new values show once the write cycle ends.
- R8: The busy flag rises in the cycle after an end of frame that has an accepted request pending. It stays high for exactly WR_CYCLES cycles.
- R9: While a write cycle runs, the status byte reads 0xFF and permit stays low.
- R10: When a write cycle ends, the latch is 0.
- R11: A status write and an array write in the same cycle are handled as a status write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| wel_set_i | input | 1 | Set-latch command strobe |
| wel_clr_i | input | 1 | Clear-latch command strobe |
| sr_wr_i | input | 1 | Status write request |
| sr_data_i | input | 8 | Status write data |
| arr_wr_i | input | 1 | Array byte write request |
| arr_addr_i | input | ADDR_W | Array byte address |
| frame_end_i | input | 1 | Chip select rose (end of frame) |
| wp_ni | input | 1 | Protect pin, active low |
| permit_o | output | 1 | Current request is allowed |
| status_o | output | 8 | Status byte |

## Verification
On every cycle the checker enforces several rules:

- Permit never coexists with a busy flag or a cleared latch.
- The status byte is 0xFF during a cycle, and bits 6:4 are zero when idle.
- The range selector shown in the status byte refuses array writes to the matching addresses.
- The pin lock refuses status writes.
- The busy flag starts only after an end of frame, lasts exactly WR_CYCLES cycles and leaves the latch cleared.

Some behaviour only the bench scenarios can show:

- The deferred loading of only bits 7 and 3:2 of a status write.
- Latch commands being ignored during a cycle.
- The precedence of a status write over a simultaneous array write.
- The absence of a cycle after an empty frame.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

   typedef logic [1:0] bp_t;

   typedef struct packed {
      logic wpen;
      bp_t  bp;
      logic wel;
   } ctl_t;

   localparam logic [7:0] BUSY_BYTE = 8'hFF;

   function automatic logic [7:0] pack_status(input ctl_t c, input logic wip);
      return {c.wpen, 3'b000, c.bp, c.wel, wip};
   endfunction

endpackage

// File: rtl/wbp_region_guard.sv
module wbp_region_guard
   import wbp_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  bp_t               bp_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              blocked_o
);
   localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};
   localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};

   always_comb begin
      case (bp_i)
         2'b00:   blocked_o = 1'b0;
         2'b01:   blocked_o = (addr_i >= QTR_BASE);
         2'b10:   blocked_o = (addr_i >= HALF_BASE);
         default: blocked_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/wbp_cycle_timer.sv
module wbp_cycle_timer #(
   parameter int WR_CYCLES = 5000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = $clog2(WR_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= LOAD;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/wbp_status_bank.sv
module wbp_status_bank
   import wbp_pkg::*;
#(
   parameter logic       WPEN_RST = 1'b0,
   parameter logic [1:0] BP_RST   = 2'b00
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       idle_i,
   input  logic       wel_set_i,
   input  logic       wel_clr_i,
   input  logic       sr_take_i,
   input  logic       arr_take_i,
   input  logic [2:0] sr_bits_i,
   input  logic       start_i,
   input  logic       done_i,
   output ctl_t       ctl_o,
   output logic       pend_o
);
   ctl_t       ctl_q;
   logic       pend_q;
   logic       sr_q;
   logic [2:0] shadow_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctl_q    <= '{wpen: WPEN_RST, bp: BP_RST, wel: 1'b0};
         pend_q   <= 1'b0;
         sr_q     <= 1'b0;
         shadow_q <= '0;
      end else if (done_i) begin
         ctl_q.wel <= 1'b0;
         if (sr_q) begin
            ctl_q.wpen <= shadow_q[2];
            ctl_q.bp   <= shadow_q[1:0];
         end
         sr_q <= 1'b0;
      end else if (start_i) begin
         pend_q <= 1'b0;
      end else if (idle_i) begin
         if (sr_take_i) begin
            pend_q   <= 1'b1;
            sr_q     <= 1'b1;
            shadow_q <= sr_bits_i;
         end else if (arr_take_i) begin
            pend_q <= 1'b1;
         end else if (wel_set_i) begin
            ctl_q.wel <= 1'b1;
         end else if (wel_clr_i) begin
            ctl_q.wel <= 1'b0;
         end
      end
   end

   assign ctl_o  = ctl_q;
   assign pend_o = pend_q;
endmodule

// File: rtl/wbp_ctrl.sv
module wbp_ctrl
   import wbp_pkg::*;
#(
   parameter int         ADDR_W    = 11,
   parameter int         WR_CYCLES = 5000,
   parameter logic       WPEN_RST  = 1'b0,
   parameter logic [1:0] BP_RST    = 2'b00,
   parameter bit         BUSY_MASK = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wel_set_i,
   input  logic              wel_clr_i,
   input  logic              sr_wr_i,
   input  logic [7:0]        sr_data_i,
   input  logic              arr_wr_i,
   input  logic [ADDR_W-1:0] arr_addr_i,
   input  logic              frame_end_i,
   input  logic              wp_ni,
   output logic              permit_o,
   output logic [7:0]        status_o
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("wbp_ctrl: ADDR_W must be at least 3");
   end
   if (WR_CYCLES < 1) begin : g_bad_cycles
      $error("wbp_ctrl: WR_CYCLES must be at least 1");
   end

   ctl_t ctl;
   logic busy, done, pend, blocked;
   logic can_wr, sr_ok, start, idle;
   logic unused_data;

   assign unused_data = ^{sr_data_i[6:4], sr_data_i[1:0]};

   wbp_region_guard #(.ADDR_W(ADDR_W)) i_guard (
      .bp_i      (ctl.bp),
      .addr_i    (arr_addr_i),
      .blocked_o (blocked)
   );

   assign idle   = !busy && !frame_end_i;
   assign can_wr = idle && ctl.wel;
   assign sr_ok  = !(ctl.wpen && !wp_ni);
   assign permit_o = can_wr && (sr_wr_i ? sr_ok : (arr_wr_i && !blocked));
   assign start  = frame_end_i && pend && !busy;

   wbp_cycle_timer #(.WR_CYCLES(WR_CYCLES)) i_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .busy_o  (busy),
      .done_o  (done)
   );

   wbp_status_bank #(.WPEN_RST(WPEN_RST), .BP_RST(BP_RST)) i_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .idle_i     (idle),
      .wel_set_i  (wel_set_i),
      .wel_clr_i  (wel_clr_i),
      .sr_take_i  (sr_wr_i && permit_o),
      .arr_take_i (arr_wr_i && !sr_wr_i && permit_o),
      .sr_bits_i  ({sr_data_i[7], sr_data_i[3:2]}),
      .start_i    (start),
      .done_i     (done),
      .ctl_o      (ctl),
      .pend_o     (pend)
   );

   if (BUSY_MASK) begin : g_mask_busy
      assign status_o = busy ? BUSY_BYTE : pack_status(ctl, 1'b0);
   end else begin : g_plain_busy
      assign status_o = pack_status(ctl, busy);
   end
endmodule

// File: rtl/wbp_ctrl_chk.sv
module wbp_ctrl_chk #(
   parameter int ADDR_W    = 11,
   parameter int WR_CYCLES = 5000,
   parameter bit BUSY_MASK = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              sr_wr_i,
   input logic              arr_wr_i,
   input logic [ADDR_W-1:0] arr_addr_i,
   input logic              frame_end_i,
   input logic              wp_ni,
   input logic              permit_o,
   input logic [7:0]        status_o
);
   localparam logic [ADDR_W-1:0] QTR  = {2'b11, {(ADDR_W-2){1'b0}}};
   localparam logic [ADDR_W-1:0] HALF = {1'b1, {(ADDR_W-1){1'b0}}};

   int unsigned run_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          run_q <= 0;
      else if (status_o[0]) run_q <= run_q + 1;
      else                  run_q <= 0;
   end

   if (BUSY_MASK) begin : g_ff
      // R9
      busy_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         status_o[0] |-> status_o == 8'hFF);
   end

   // R9
   busy_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[0] |-> !permit_o);

   // R4
   wel_need_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      permit_o |-> status_o[1] && !frame_end_i);

   // R3
   dc_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !status_o[0] |-> status_o[6:4] == 3'b000);

   // R5
   prot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arr_wr_i && !sr_wr_i && !status_o[0] &&
       ((status_o[3:2] == 2'b11) ||
        (status_o[3:2] == 2'b10 && arr_addr_i >= HALF) ||
        (status_o[3:2] == 2'b01 && arr_addr_i >= QTR))) |-> !permit_o);

   // R6
   wp_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sr_wr_i && !status_o[0] && status_o[7] && !wp_ni) |-> !permit_o);

   // R8
   wip_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[0]) |-> $past(frame_end_i));

   // R8
   wip_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_o[0]) |-> run_q == WR_CYCLES);

   // R10
   wel_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_o[0]) |-> !status_o[1]);
endmodule

bind wbp_ctrl wbp_ctrl_chk #(
   .ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES), .BUSY_MASK(BUSY_MASK)
) i_wbp_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .sr_wr_i     (sr_wr_i),
   .arr_wr_i    (arr_wr_i),
   .arr_addr_i  (arr_addr_i),
   .frame_end_i (frame_end_i),
   .wp_ni       (wp_ni),
   .permit_o    (permit_o),
   .status_o    (status_o)
);

// File: tb/test_wbp_ctrl.sv
module test_wbp_ctrl;
   localparam int AW   = 11;
   localparam int NCYC = 12;

   logic clk = 1'b0;
   logic rst_n;
   always #5 clk = ~clk;

   logic          wel_set, wel_clr, sr_wr, arr_wr, frame_end, wp_n;
   logic [7:0]    sr_data;
   logic [AW-1:0] addr;
   logic          permit;
   logic [7:0]    status;

   wbp_ctrl #(.ADDR_W(AW), .WR_CYCLES(NCYC)) i_wbp_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .wel_set_i(wel_set), .wel_clr_i(wel_clr),
      .sr_wr_i(sr_wr), .sr_data_i(sr_data), .arr_wr_i(arr_wr), .arr_addr_i(addr),
      .frame_end_i(frame_end), .wp_ni(wp_n), .permit_o(permit), .status_o(status)
   );

   int checks = 0;
   int fails  = 0;

   // reference model state
   logic       m_wel, m_wpen, m_pend, m_sr;
   logic [1:0] m_bp;
   logic [7:0] m_sh;
   int         m_left;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic blocked(input logic [AW-1:0] a);
      case (m_bp)
         2'b00:   return 1'b0;
         2'b01:   return a[AW-1] & a[AW-2];
         2'b10:   return a[AW-1];
         default: return 1'b1;
      endcase
   endfunction

   function automatic logic exp_permit(input logic sw, input logic aw, input logic fe,
                                       input logic wp, input logic [AW-1:0] a);
      if (m_left > 0 || !m_wel || fe) return 1'b0;
      if (sw) return !(m_wpen && !wp);
      if (aw) return !blocked(a);
      return 1'b0;
   endfunction

   function automatic logic [7:0] exp_status();
      if (m_left > 0) return 8'hFF;
      return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
   endfunction

   task automatic step(input logic s, input logic c, input logic sw, input logic aw,
                       input logic fe, input logic wp, input logic [7:0] d,
                       input logic [AW-1:0] a, input string tag);
      logic p;
      @(negedge clk);
      wel_set = s; wel_clr = c; sr_wr = sw; arr_wr = aw; frame_end = fe;
      wp_n = wp; sr_data = d; addr = a;
      #1;
      p = exp_permit(sw, aw, fe, wp, a);
      if (sw || aw) chk(tag, {7'b0, permit}, {7'b0, p});
      @(posedge clk);
      if (m_left > 0) begin
         if (m_left == 1) begin
            m_wel = 1'b0;
            if (m_sr) begin m_wpen = m_sh[7]; m_bp = m_sh[3:2]; end
            m_sr = 1'b0;
         end
         m_left--;
      end else if (fe) begin
         if (m_pend) begin m_left = NCYC; m_pend = 1'b0; end
      end else if (sw && p) begin
         m_pend = 1'b1; m_sr = 1'b1; m_sh = d;
      end else if (aw && p) begin
         m_pend = 1'b1;
      end else if (s) m_wel = 1'b1;
      else if (c) m_wel = 1'b0;
      #2;
      chk("R3", status, exp_status());
   endtask

   task automatic idle();           step(0,0,0,0,0,1,8'h00,'0,"R3"); endtask
   task automatic wren();           step(1,0,0,0,0,1,8'h00,'0,"R2"); endtask
   task automatic wrdi();           step(0,1,0,0,0,1,8'h00,'0,"R2"); endtask
   task automatic fend();           step(0,0,0,0,1,1,8'h00,'0,"R4"); endtask
   task automatic wrsr(input logic [7:0] d, input logic wp, input string t);
      step(0,0,1,0,0,wp,d,'0,t);
   endtask
   task automatic wr(input logic [AW-1:0] a, input string t);
      step(0,0,0,1,0,1,8'h00,a,t);
   endtask
   task automatic wait_idle();
      while (status[0]) idle();
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n;
      rst_n = 1'b0;
      wel_set = 0; wel_clr = 0; sr_wr = 0; arr_wr = 0; frame_end = 0;
      wp_n = 1; sr_data = 0; addr = '0;
      m_wel = 0; m_wpen = 0; m_pend = 0; m_sr = 0; m_bp = 2'b00; m_sh = 0; m_left = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1 chk("R1", status, 8'h00);

      // no latch: refused, empty frame starts nothing
      wrsr(8'h8C, 1'b1, "R4");
      fend();
      chk("R4", status, 8'h00);

      // latch set/clear
      wren(); chk("R2", status, 8'h02);
      wrdi(); chk("R2", status, 8'h00);
      wren();

      // status write with all data bits set
      wrsr(8'hFF, 1'b1, "R7");
      fend();
      n = 1;
      chk("R9", status, 8'hFF);
      wren(); n++;
      wr('0, "R9"); n++;
      while (status[0]) begin idle(); if (status[0]) n++; end
      chk("R8", n[7:0], NCYC[7:0]);
      chk("R7", status, 8'h8C);
      chk("R2", {7'b0, status[1]}, 8'h00);

      // pin lock
      wren();
      wrsr(8'h04, 1'b0, "R6");
      wr(11'h000, "R5");
      wrsr(8'h04, 1'b1, "R6");
      fend(); wait_idle();
      chk("R7", status, 8'h04);

      // quarter protection
      wren();
      wr(11'h5FF, "R5");
      wr(11'h600, "R5");
      wr(11'h7FF, "R5");
      fend(); wait_idle();
      chk("R10", status, 8'h04);

      // pin ignored with enable 0
      wren();
      wrsr(8'h08, 1'b0, "R6");
      fend(); wait_idle();
      chk("R6", status, 8'h08);

      // half protection
      wren();
      wr(11'h3FF, "R5");
      wr(11'h400, "R5");
      fend(); wait_idle();
      wrdi();
      wr(11'h000, "R4");
      fend();
      chk("R4", status, 8'h08);

      // simultaneous status and array write
      wren();
      step(0,0,1,1,0,1,8'h00,11'h000,"R11");
      fend(); wait_idle();
      chk("R11", status, 8'h00);

      // constrained random
      void'($urandom(32'h5A17));
      for (int i = 0; i < 800; i++) begin
         int r;
         r = $urandom % 10;
         case (r)
            0, 1: wren();
            2:    wrdi();
            3, 4: wr(AW'($urandom), "R5");
            5:    wrsr(8'($urandom), 1'($urandom), "R6");
            6, 7: fend();
            default: idle();
         endcase
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule